// File: doc/BRIEF.md
# Byte-Lane Delay Trend Checker

The block scores a set of per-lane read-leveling delays for how well they follow the steady rise or fall that a fly-by routed memory module produces across its byte lanes. A packed rank word carries one 6-bit delay per lane. A caller supplies the word together with a first and a last lane index, a largest permitted step between neighbours and a switch that turns off the direction check. It then pulses `start_i`.

The block latches the request and walks from the first lane toward the last lane, one neighbour pair per clock. It accumulates two kinds of fixed penalties. A lane that moves against the overall direction costs 50. A step between neighbours that is larger than the permitted step costs 30. When the walk ends, a one-cycle `done_o` pulse marks the final total on `penalty_o`. The total stays there until the next accepted request.

Top module: `ltc_trend_checker`

## Requirements
- R1: Lane k's delay occupies bits [6k+5:6k] of `rank_word_i` (lane 0 in the least significant bits). No other bits affect the result for that lane.
- R2: The expected direction is the sign of (delay of last lane − delay of first lane): positive means rising, negative means falling. Zero means flat, and under a flat trend no lane counts as going against the direction.
- R3: For each walked pair (previous lane, next lane), the pair adds 50 when the next delay is strictly lower under a rising trend, or strictly higher under a falling trend. Equal delays never add this penalty.
- R4: A pair adds 30 when the absolute difference of its two delays is strictly greater than `max_step_i`. A difference equal to `max_step_i` adds nothing. Both penalties may apply to the same pair.
- R5: `max_step_i` = 0 switches the step penalty off entirely.
- R6: `seq_chk_off_i` = 1 switches off the direction penalty only. Step penalties still apply.
- R7: The walk goes from the first lane to the last lane in whichever order they are given, ascending or descending. An index at or above the lane count is treated as the highest lane.
- R8: With N = |last − first| after clamping, `done_o` is a single-cycle pulse exactly max(N,1) clock cycles after the cycle in which `start_i` is accepted. `busy_o` is high between acceptance and that pulse.
- R9: `start_i` is ignored while `busy_o` is high. `penalty_o` clears when a request is accepted and then keeps the final total unchanged until the next accepted request.
- R10: After reset `busy_o` and `done_o` are low and `penalty_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, accepted only while idle |
| rank_word_i | input | LANES*6 | Packed lane delays, 6 bits per lane |
| first_lane_i | input | IDX_W | Lane where the walk begins |
| last_lane_i | input | IDX_W | Lane where the walk ends |
| max_step_i | input | 6 | Largest allowed neighbour step, 0 disables step check |
| seq_chk_off_i | input | 1 | Disables the direction check |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse: penalty_o holds the final total |
| penalty_o | output | PEN_W | Accumulated penalty |

## Verification
The hardest situation to reach from the ports is a pair that draws both penalties at once while the trend is set by the end lanes and not by the pair itself. Purely random words seldom have end lanes that differ and also contain a large reversal in the middle. The stimulus therefore builds noisy ramps with occasional inserted spikes, walks them in both orders, and adds directed words with a single steep dip. Directed cases also cover a step exactly equal to the limit, clamped indices, single-lane walks and a second start issued mid-walk.

// File: rtl/ltc_pkg.sv
package ltc_pkg;
  localparam int unsigned DLY_W    = 6;
  localparam int unsigned DIR_PEN  = 50;
  localparam int unsigned STEP_PEN = 30;
  localparam int unsigned PAIR_W   = $clog2(DIR_PEN + STEP_PEN + 1);

  typedef logic [DLY_W-1:0] dly_t;

  typedef enum logic [1:0] {
    TR_FLAT = 2'd0,
    TR_RISE = 2'd1,
    TR_FALL = 2'd2
  } trend_e;

  // Overall direction from the end-point delays.
  function automatic trend_e trend_of(dly_t from_d, dly_t to_d);
    if (to_d > from_d) return TR_RISE;
    if (to_d < from_d) return TR_FALL;
    return TR_FLAT;
  endfunction

  // True when the pair moves strictly against the trend.
  function automatic logic against_trend(trend_e t, dly_t prev_d, dly_t next_d);
    case (t)
      TR_RISE: return next_d < prev_d;
      TR_FALL: return next_d > prev_d;
      default: return 1'b0;
    endcase
  endfunction

  // Magnitude of the step between neighbours.
  function automatic dly_t step_size(dly_t a, dly_t b);
    return (a > b) ? (a - b) : (b - a);
  endfunction
endpackage

// File: rtl/ltc_lane_pick.sv
module ltc_lane_pick
  import ltc_pkg::*;
#(
  parameter int unsigned LANES = 9,
  parameter int unsigned NSEL  = 4,
  parameter int unsigned IDX_W = 4
) (
  input  logic [LANES*DLY_W-1:0] word_i,
  input  logic [NSEL*IDX_W-1:0]  sel_i,
  output logic [NSEL*DLY_W-1:0]  dly_o
);
  dly_t lane_d [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_d[k] = word_i[k*DLY_W +: DLY_W];
  end

  for (genvar s = 0; s < NSEL; s++) begin : g_sel
    dly_t hit;
    always_comb begin
      hit = '0;
      for (int k = 0; k < LANES; k++) begin
        if (sel_i[s*IDX_W +: IDX_W] == IDX_W'(k)) hit = lane_d[k];
      end
    end
    assign dly_o[s*DLY_W +: DLY_W] = hit;
  end
endmodule

// File: rtl/ltc_pair_judge.sv
module ltc_pair_judge
  import ltc_pkg::*;
(
  input  dly_t              prev_d_i,
  input  dly_t              next_d_i,
  input  trend_e            trend_i,
  input  dly_t              max_step_i,
  input  logic              seq_off_i,
  output logic              dir_bad_o,
  output logic              step_bad_o,
  output logic [PAIR_W-1:0] pen_o
);
  dly_t step;

  always_comb begin
    step       = step_size(prev_d_i, next_d_i);
    dir_bad_o  = !seq_off_i && against_trend(trend_i, prev_d_i, next_d_i);
    step_bad_o = (max_step_i != '0) && (step > max_step_i);
    pen_o      = (dir_bad_o  ? PAIR_W'(DIR_PEN)  : '0)
               + (step_bad_o ? PAIR_W'(STEP_PEN) : '0);
  end
endmodule

// File: rtl/ltc_walker.sv
module ltc_walker #(
  parameter int unsigned LANES = 9,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IDX_W-1:0] first_i,
  input  logic [IDX_W-1:0] last_i,
  output logic             accept_o,
  output logic             step_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [IDX_W-1:0] first_q_o,
  output logic [IDX_W-1:0] last_q_o,
  output logic [IDX_W-1:0] prev_o,
  output logic [IDX_W-1:0] next_o
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(LANES - 1);

  typedef enum logic [1:0] {W_IDLE, W_RUN, W_FIN} wst_e;

  wst_e             st;
  logic             up_q;
  logic [IDX_W-1:0] f_c, l_c;

  function automatic logic [IDX_W-1:0] clamp(logic [IDX_W-1:0] i);
    return (i > TOP_IDX) ? TOP_IDX : i;
  endfunction

  assign f_c       = clamp(first_i);
  assign l_c       = clamp(last_i);
  assign accept_o  = (st == W_IDLE) && start_i;
  assign step_en_o = (st == W_RUN);
  assign busy_o    = (st != W_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= W_IDLE;
      up_q      <= 1'b0;
      done_o    <= 1'b0;
      first_q_o <= '0;
      last_q_o  <= '0;
      prev_o    <= '0;
      next_o    <= '0;
    end else begin
      done_o <= 1'b0;
      case (st)
        W_IDLE: begin
          if (start_i) begin
            first_q_o <= f_c;
            last_q_o  <= l_c;
            prev_o    <= f_c;
            up_q      <= (l_c > f_c);
            if (l_c > f_c)      next_o <= f_c + 1'b1;
            else if (l_c < f_c) next_o <= f_c - 1'b1;
            else                next_o <= f_c;
            st <= (l_c == f_c) ? W_FIN : W_RUN;
          end
        end
        W_RUN: begin
          if (next_o == last_q_o) begin
            st     <= W_IDLE;
            done_o <= 1'b1;
          end else begin
            prev_o <= next_o;
            next_o <= up_q ? next_o + 1'b1 : next_o - 1'b1;
          end
        end
        W_FIN: begin
          st     <= W_IDLE;
          done_o <= 1'b1;
        end
        default: st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ltc_trend_checker.sv
module ltc_trend_checker
  import ltc_pkg::*;
#(
  parameter int unsigned LANES = 9,
  localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int unsigned WORD_W = LANES * DLY_W,
  localparam int unsigned PEN_W = $clog2((DIR_PEN + STEP_PEN) * LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] rank_word_i,
  input  logic [IDX_W-1:0]  first_lane_i,
  input  logic [IDX_W-1:0]  last_lane_i,
  input  logic [DLY_W-1:0]  max_step_i,
  input  logic              seq_chk_off_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [PEN_W-1:0]  penalty_o
);
  logic              accept, step_en;
  logic [IDX_W-1:0]  first_q, last_q, prev_idx, next_idx;
  logic [WORD_W-1:0] word_q;
  dly_t              max_step_q;
  logic              seq_off_q;
  logic [4*DLY_W-1:0] picked;
  dly_t              d_first, d_last, d_prev, d_next;
  trend_e            trend;
  logic              dir_bad, step_bad;
  logic [PAIR_W-1:0] pair_pen;

  ltc_walker #(.LANES(LANES), .IDX_W(IDX_W)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .first_i   (first_lane_i),
    .last_i    (last_lane_i),
    .accept_o  (accept),
    .step_en_o (step_en),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .first_q_o (first_q),
    .last_q_o  (last_q),
    .prev_o    (prev_idx),
    .next_o    (next_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q     <= '0;
      max_step_q <= '0;
      seq_off_q  <= 1'b0;
    end else if (accept) begin
      word_q     <= rank_word_i;
      max_step_q <= max_step_i;
      seq_off_q  <= seq_chk_off_i;
    end
  end

  ltc_lane_pick #(.LANES(LANES), .NSEL(4), .IDX_W(IDX_W)) u_pick (
    .word_i (word_q),
    .sel_i  ({next_idx, prev_idx, last_q, first_q}),
    .dly_o  (picked)
  );

  assign d_first = picked[0*DLY_W +: DLY_W];
  assign d_last  = picked[1*DLY_W +: DLY_W];
  assign d_prev  = picked[2*DLY_W +: DLY_W];
  assign d_next  = picked[3*DLY_W +: DLY_W];
  assign trend   = trend_of(d_first, d_last);

  ltc_pair_judge u_judge (
    .prev_d_i   (d_prev),
    .next_d_i   (d_next),
    .trend_i    (trend),
    .max_step_i (max_step_q),
    .seq_off_i  (seq_off_q),
    .dir_bad_o  (dir_bad),
    .step_bad_o (step_bad),
    .pen_o      (pair_pen)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       penalty_o <= '0;
    else if (accept)  penalty_o <= '0;
    else if (step_en) penalty_o <= penalty_o + PEN_W'(pair_pen);
  end
endmodule

// File: rtl/ltc_trend_checker_sva.sv
module ltc_trend_checker_sva
  import ltc_pkg::*;
#(
  parameter int unsigned LANES = 9,
  localparam int unsigned PEN_W = $clog2((DIR_PEN + STEP_PEN) * LANES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [PEN_W-1:0] penalty_o,
  input logic             dir_bad,
  input logic             step_bad,
  input trend_e           trend,
  input logic             seq_off_q,
  input dly_t             max_step_q
);
  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_o));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(penalty_o));
  a_r9_grow_only: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (penalty_o >= $past(penalty_o)));
  a_r6_dir_off: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && seq_off_q) |-> !dir_bad);
  a_r5_step_off: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && max_step_q == '0) |-> !step_bad);
  a_r2_flat_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && trend == TR_FLAT) |-> !dir_bad);
endmodule

bind ltc_trend_checker ltc_trend_checker_sva #(.LANES(LANES)) u_sva (.*);

// File: tb/tb_ltc_trend_checker.sv
`timescale 1ns/1ps
module tb_ltc_trend_checker;
  localparam int LANES = 9;
  localparam int IDX_W = 4;
  localparam int WW    = LANES * 6;
  localparam int PEN_W = $clog2(80 * LANES + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [WW-1:0]    rank_word_i = '0;
  logic [IDX_W-1:0] first_lane_i = '0;
  logic [IDX_W-1:0] last_lane_i = '0;
  logic [5:0]       max_step_i = '0;
  logic             seq_chk_off_i = 1'b0;
  logic             busy_o, done_o;
  logic [PEN_W-1:0] penalty_o;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  ltc_trend_checker #(.LANES(LANES)) dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fld(logic [WW-1:0] w, int k);
    return int'((w >> (6 * k)) & 54'h3F);
  endfunction

  function automatic int clampi(int i);
    return (i > LANES - 1) ? LANES - 1 : i;
  endfunction

  function automatic int model(logic [WW-1:0] w, int f, int l, int ms, bit off);
    int cf = clampi(f);
    int cl = clampi(l);
    int dir = (fld(w, cl) > fld(w, cf)) ? 1 : (fld(w, cl) < fld(w, cf)) ? -1 : 0;
    int p = cf;
    int sum = 0;
    while (p != cl) begin
      int c = (cl > cf) ? p + 1 : p - 1;
      int a = fld(w, p);
      int b = fld(w, c);
      int mag = (a > b) ? a - b : b - a;
      if (!off && ((dir == 1 && b < a) || (dir == -1 && b > a))) sum += 50;
      if (ms != 0 && mag > ms) sum += 30;
      p = c;
    end
    return sum;
  endfunction

  function automatic logic [WW-1:0] pack(int d0, int d1, int d2, int d3, int d4,
                                         int d5, int d6, int d7, int d8);
    int v[9] = '{d0, d1, d2, d3, d4, d5, d6, d7, d8};
    logic [WW-1:0] w = '0;
    for (int k = 0; k < 9; k++) w[k*6 +: 6] = 6'(v[k]);
    return w;
  endfunction

  task automatic run(input logic [WW-1:0] w, input int f, input int l, input int ms,
                     input bit off, input string req, input bit disturb);
    int exp = model(w, f, l, ms, off);
    int n = clampi(l) - clampi(f);
    int lat;
    int cyc = 0;
    bit busy_ok = 1'b1;
    if (n < 0) n = -n;
    lat = (n < 1) ? 1 : n;
    @(negedge clk);
    rank_word_i = w; first_lane_i = IDX_W'(f); last_lane_i = IDX_W'(l);
    max_step_i = 6'(ms); seq_chk_off_i = off; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o && cyc < 100) begin
      if (!busy_o) busy_ok = 1'b0;
      if (disturb && cyc == 1) begin
        rank_word_i = ~w; first_lane_i = IDX_W'(l); last_lane_i = IDX_W'(f);
        max_step_i = 6'd1; seq_chk_off_i = ~off; start_i = 1'b1;
      end
      @(negedge clk);
      start_i = 1'b0;
      cyc++;
    end
    if (cyc >= 100) begin
      check(1'b0, "watchdog", cyc, lat);
      return;
    end
    check(busy_ok, "R8 busy during walk", busy_ok, 1);
    check(cyc == lat, "R8 latency", cyc, lat);
    check(int'(penalty_o) == exp, req, int'(penalty_o), exp);
    @(negedge clk);
    check(!done_o, "R8 done one cycle", done_o, 0);
    check(int'(penalty_o) == exp, "R9 penalty held", int'(penalty_o), exp);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    #1;
    check(!busy_o && !done_o && penalty_o == 0, "R10 reset state", int'(penalty_o), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o && penalty_o == 0, "R10 after release", int'(penalty_o), 0);

    // R1: lanes 2 and 3 only, other fields full of ones
    run(pack(63, 63, 10, 40, 63, 63, 63, 63, 63), 2, 3, 5, 0, "R1 lane field", 0);
    // R2 ascending ramp, no penalty
    run(pack(2, 4, 6, 8, 10, 12, 14, 16, 18), 0, 8, 0, 0, "R2 clean ramp", 0);
    // R3 one dip under rising trend
    run(pack(2, 4, 6, 5, 10, 12, 14, 16, 18), 0, 8, 0, 0, "R3 one dip", 0);
    // R3 equal neighbours never penalised
    run(pack(2, 4, 4, 8, 8, 12, 14, 16, 18), 0, 8, 0, 0, "R3 equal pair", 0);
    // R4 step exactly at limit, then one over
    run(pack(0, 5, 10, 15, 20, 25, 30, 35, 40), 0, 8, 5, 0, "R4 step at limit", 0);
    run(pack(0, 5, 10, 16, 20, 25, 30, 35, 40), 0, 8, 5, 0, "R4 step over limit", 0);
    // R3+R4 both on one pair
    run(pack(10, 12, 14, 1, 16, 18, 20, 22, 24), 0, 8, 4, 0, "R4 both penalties", 0);
    // R5 limit 0 disables step check
    run(pack(0, 60, 2, 50, 4, 40, 6, 30, 63), 0, 8, 0, 0, "R5 step off", 0);
    // R6 direction off, steps still counted
    run(pack(0, 60, 2, 50, 4, 40, 6, 30, 63), 0, 8, 20, 1, "R6 dir off", 0);
    // R7 descending walk
    run(pack(2, 4, 6, 5, 10, 12, 14, 16, 18), 8, 0, 3, 0, "R7 reverse walk", 0);
    // R7 clamp of out-of-range index
    run(pack(30, 28, 26, 27, 22, 20, 18, 16, 14), 0, 15, 3, 0, "R7 clamp", 0);
    run(pack(30, 28, 26, 27, 22, 20, 18, 16, 14), 13, 2, 3, 0, "R7 clamp first", 0);
    // R8 single lane
    run(pack(1, 2, 3, 4, 5, 6, 7, 8, 9), 3, 3, 1, 0, "R8 single lane", 0);
    // R2 flat trend with bump
    run(pack(20, 30, 10, 50, 5, 20, 0, 0, 0), 0, 5, 0, 0, "R2 flat", 0);
    // R9 start while busy ignored
    run(pack(2, 4, 6, 5, 10, 12, 14, 16, 18), 0, 8, 1, 0, "R9 start ignored", 1);
    // R9 penalty holds over idle cycles
    repeat (5) @(negedge clk);
    check(!done_o && !busy_o, "R9 idle", busy_o, 0);

    for (int t = 0; t < 300; t++) begin
      logic [WW-1:0] w = '0;
      int base = $urandom_range(0, 63);
      int slope = $urandom_range(0, 6) - 3;
      int f = $urandom_range(0, 15);
      int l = $urandom_range(0, 15);
      int ms = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(1, 12);
      bit off = ($urandom_range(0, 4) == 0);
      for (int k = 0; k < LANES; k++) begin
        int v = base + slope * k + $urandom_range(0, 4) - 2;
        if ($urandom_range(0, 7) == 0) v = v + $urandom_range(0, 40) - 20;
        if (v < 0) v = 0;
        if (v > 63) v = 63;
        w[k*6 +: 6] = 6'(v);
      end
      run(w, f, l, ms, off, "R3 R4 random", ($urandom_range(0, 9) == 0));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule